// File: doc/BRIEF.md
# Retention-Binned Row Refresh Sequencer

This block drives per-row refresh for one DRAM rank. Rows are not all refreshed at the worst-case rate. Each row belongs to a refresh class. Rows known to hold data only briefly are refreshed every round. Rows with medium retention are refreshed every second round. All other rows are refreshed every fourth round. Class membership lives in two hardware Bloom filters, so the block keeps no storage for each row. A filter can report a row as present when it was never inserted, which only causes extra refreshes. A row that was inserted is always reported as present. A filter cannot overflow.

The block is used in two steps. First, after the rows have been profiled, the weak rows are inserted through a valid/ready port. Each insertion carries a row address and a class bit. Then one tick pulse is applied per base interval. Each tick starts a sweep over all rows in ascending order. For every row, the block decides from the round number and from probes of the filters whether to emit the row on the refresh output. The refresh output uses its own valid/ready handshake.

Top module: `retention_refresh_ctrl`

## Requirements
- R1: After synchronous reset, `ref_valid` is 0, `ins_ready` is 1, both filters are empty and the round number is 0.
- R2: Index k of a filter with 2^W bits is computed as follows. Take v = row XOR (0x9E3779B1 * (k+1)) as a 32-bit value. Bit b of v is folded by XOR into index bit b mod W. An accepted insertion (`ins_valid` and `ins_ready` high on the same edge) sets the bits for k = 0 to H-1 in the fast filter when `ins_bin`=0, or in the slow filter when `ins_bin`=1. `ins_ready` stays low until the insertion is done.
- R3: In a round whose number mod 4 is 0, every row is emitted once, in ascending order.
- R4: A row whose fast-filter bits are all set is emitted in every round.
- R5: In even rounds, a row whose slow-filter bits are all set is emitted.
- R6: In any other case a row is skipped. Within a round, rows are emitted at most once each and in ascending order. The round number increases by one after each sweep.
- R7: A row present in both filters is emitted once per round, at the fast rate.
- R8: While `ref_valid` is high and `ref_ready` is low, `ref_valid` and `ref_row` hold their values.
- R9: While a sweep is in progress, `ins_ready` is low and no insertion is accepted.
- R10: A tick that arrives while the block is busy is held. It starts one more sweep as soon as the block returns to idle. Further ticks that arrive during the same busy period are merged into that one held tick.
- R11: A pulse on `clr_filters` empties both filters.
- R12: In idle, a tick takes priority over a pending insertion. The insertion is accepted only after the sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_filters | input | 1 | Synchronous clear of both filters |
| tick | input | 1 | One-cycle pulse per base interval; starts a sweep |
| ins_valid | input | 1 | Insertion request |
| ins_ready | output | 1 | Insertion can be accepted |
| ins_row | input | ROW_W | Row to insert |
| ins_bin | input | 1 | 0 = fast class, 1 = slow class |
| ref_valid | output | 1 | Refresh request valid |
| ref_ready | input | 1 | Refresh request taken |
| ref_row | output | ROW_W | Row to refresh |

## Verification
The hardest case to reach from the ports is a tick that arrives while a sweep is already running. The held tick must then chain a second sweep with no idle window in which an insertion could slip in. The bench reaches this case by pulsing tick a few cycles into a sweep. It then checks the refreshed rows of two consecutive rounds against one list that joins the expected rows of both rounds. The bench also drives a tick and an insertion in the same idle cycle, which exercises the priority rule. Expected rows come from a filter model in the bench. That model computes the hash by slicing, not by per-bit folding. Because of this, false positives in the small configuration are predicted rather than avoided.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INS,
        ST_ROW,
        ST_PF,
        ST_PS,
        ST_ISSUE
    } seq_state_e;

    typedef enum logic {
        BIN_FAST = 1'b0,
        BIN_SLOW = 1'b1
    } bin_e;

    localparam logic [31:0] HASH_SEED_MUL = 32'h9E3779B1;

    // Index of hash number seed: row mixed with a seed, folded onto w bits.
    function automatic logic [31:0] fold_index(input logic [31:0] row,
                                               input int unsigned seed,
                                               input int unsigned w);
        logic [31:0] v;
        logic [31:0] idx;
        v   = row ^ (HASH_SEED_MUL * 32'(seed + 1));
        idx = '0;
        for (int b = 0; b < 32; b++) begin
            idx[b % w] = idx[b % w] ^ v[b];
        end
        return idx;
    endfunction

endpackage

// File: rtl/rrc_bloom.sv
module rrc_bloom #(
    parameter int BITS   = 2048,
    parameter int ROW_W  = 12,
    parameter int HIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [ROW_W-1:0]  row,
    input  logic [HIDX_W-1:0] hidx,
    input  logic              set_en,
    output logic              hit
);
    localparam int IDX_W = $clog2(BITS);

    logic [BITS-1:0]  bits_q;
    logic [IDX_W-1:0] pos;

    always_comb begin
        pos = IDX_W'(rrc_pkg::fold_index(32'(row), 32'(hidx), IDX_W));
        hit = bits_q[pos];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits_q <= '0;
        end else if (set_en) begin
            bits_q[pos] <= 1'b1;
        end
    end
endmodule

// File: rtl/rrc_seq.sv
module rrc_seq
    import rrc_pkg::*;
#(
    parameter int ROW_W  = 12,
    parameter int F_HASH = 10,
    parameter int S_HASH = 6,
    parameter int HIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [ROW_W-1:0]  ins_row,
    input  logic              ins_bin,
    input  logic              fast_hit,
    input  logic              slow_hit,
    output logic [ROW_W-1:0]  probe_row,
    output logic [HIDX_W-1:0] hidx,
    output logic              fast_set,
    output logic              slow_set,
    output logic              ref_valid,
    input  logic              ref_ready,
    output logic [ROW_W-1:0]  ref_row
);
    localparam logic [HIDX_W-1:0] F_LAST = HIDX_W'(F_HASH - 1);
    localparam logic [HIDX_W-1:0] S_LAST = HIDX_W'(S_HASH - 1);

    seq_state_e        state_q, state_d;
    logic [ROW_W-1:0]  row_q, row_d, irow_q, irow_d;
    logic [HIDX_W-1:0] hidx_q, hidx_d;
    logic [1:0]        round_q, round_d;
    logic              pend_q, pend_d;
    bin_e              ibin_q, ibin_d;
    logic              adv;

    always_comb begin
        ins_ready = (state_q == ST_IDLE) && !pend_q && !tick;
        ref_valid = (state_q == ST_ISSUE);
        ref_row   = row_q;
        probe_row = (state_q == ST_INS) ? irow_q : row_q;
        hidx      = hidx_q;
        fast_set  = (state_q == ST_INS) && (ibin_q == BIN_FAST);
        slow_set  = (state_q == ST_INS) && (ibin_q == BIN_SLOW);
    end

    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        irow_d  = irow_q;
        ibin_d  = ibin_q;
        hidx_d  = hidx_q;
        round_d = round_q;
        pend_d  = pend_q;
        adv     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (tick || pend_q) begin
                    state_d = ST_ROW;
                    row_d   = '0;
                    pend_d  = 1'b0;
                end else if (ins_valid) begin
                    state_d = ST_INS;
                    irow_d  = ins_row;
                    ibin_d  = bin_e'(ins_bin);
                    hidx_d  = '0;
                end
            end
            ST_INS: begin
                if (hidx_q == ((ibin_q == BIN_FAST) ? F_LAST : S_LAST)) begin
                    state_d = ST_IDLE;
                    hidx_d  = '0;
                end else begin
                    hidx_d = hidx_q + 1'b1;
                end
            end
            ST_ROW: begin
                hidx_d  = '0;
                state_d = (round_q == 2'd0) ? ST_ISSUE : ST_PF;
            end
            ST_PF: begin
                if (!fast_hit) begin
                    if (!round_q[0]) begin
                        state_d = ST_PS;
                        hidx_d  = '0;
                    end else begin
                        adv = 1'b1;
                    end
                end else if (hidx_q == F_LAST) begin
                    state_d = ST_ISSUE;
                end else begin
                    hidx_d = hidx_q + 1'b1;
                end
            end
            ST_PS: begin
                if (!slow_hit) begin
                    adv = 1'b1;
                end else if (hidx_q == S_LAST) begin
                    state_d = ST_ISSUE;
                end else begin
                    hidx_d = hidx_q + 1'b1;
                end
            end
            ST_ISSUE: begin
                adv = ref_ready;
            end
            default: state_d = ST_IDLE;
        endcase
        if (adv) begin
            if (row_q == '1) begin
                state_d = ST_IDLE;
                round_d = round_q + 1'b1;
            end else begin
                row_d   = row_q + 1'b1;
                state_d = ST_ROW;
            end
        end
        if (tick && state_q != ST_IDLE) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            irow_q  <= '0;
            ibin_q  <= BIN_FAST;
            hidx_q  <= '0;
            round_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            irow_q  <= irow_d;
            ibin_q  <= ibin_d;
            hidx_q  <= hidx_d;
            round_q <= round_d;
            pend_q  <= pend_d;
        end
    end
endmodule

// File: rtl/retention_refresh_ctrl.sv
module retention_refresh_ctrl #(
    parameter int ROW_W       = 12,
    parameter int FAST_BITS   = 2048,
    parameter int FAST_HASHES = 10,
    parameter int SLOW_BITS   = 8192,
    parameter int SLOW_HASHES = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_filters,
    input  logic             tick,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [ROW_W-1:0] ins_row,
    input  logic             ins_bin,
    output logic             ref_valid,
    input  logic             ref_ready,
    output logic [ROW_W-1:0] ref_row
);
    localparam int HMAX   = (FAST_HASHES > SLOW_HASHES) ? FAST_HASHES : SLOW_HASHES;
    localparam int HIDX_W = (HMAX > 2) ? $clog2(HMAX) : 1;

    logic [ROW_W-1:0]  probe_row;
    logic [HIDX_W-1:0] hidx;
    logic              fast_set, slow_set, fast_hit, slow_hit;

    rrc_seq #(
        .ROW_W (ROW_W),
        .F_HASH(FAST_HASHES),
        .S_HASH(SLOW_HASHES),
        .HIDX_W(HIDX_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ins_valid(ins_valid),
        .ins_ready(ins_ready),
        .ins_row  (ins_row),
        .ins_bin  (ins_bin),
        .fast_hit (fast_hit),
        .slow_hit (slow_hit),
        .probe_row(probe_row),
        .hidx     (hidx),
        .fast_set (fast_set),
        .slow_set (slow_set),
        .ref_valid(ref_valid),
        .ref_ready(ref_ready),
        .ref_row  (ref_row)
    );

    rrc_bloom #(.BITS(FAST_BITS), .ROW_W(ROW_W), .HIDX_W(HIDX_W)) u_fast (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_filters),
        .row   (probe_row),
        .hidx  (hidx),
        .set_en(fast_set),
        .hit   (fast_hit)
    );

    rrc_bloom #(.BITS(SLOW_BITS), .ROW_W(ROW_W), .HIDX_W(HIDX_W)) u_slow (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_filters),
        .row   (probe_row),
        .hidx  (hidx),
        .set_en(slow_set),
        .hit   (slow_hit)
    );
endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             ins_valid,
    input logic             ins_ready,
    input logic             ref_valid,
    input logic             ref_ready,
    input logic [ROW_W-1:0] ref_row
);
    // R8
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid && !ref_ready |=> ref_valid && $stable(ref_row));

    // R9
    ins_block_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> !ins_ready);

    // R2
    ins_accept_chk: assert property (@(posedge clk) disable iff (rst)
        ins_valid && ins_ready |=> !ins_ready && !ref_valid);

    // R10
    tick_busy_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !ins_ready);
endmodule

bind retention_refresh_ctrl rrc_checker #(.ROW_W(ROW_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ins_valid(ins_valid),
    .ins_ready(ins_ready),
    .ref_valid(ref_valid),
    .ref_ready(ref_ready),
    .ref_row  (ref_row)
);

// File: tb/retention_refresh_ctrl_test.sv
`timescale 1ns/1ps
module retention_refresh_ctrl_test;
    localparam int RW = 4;
    localparam int NROWS = 16;
    localparam int FB = 64, FH = 3, SB = 128, SH = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_filters = 1'b0, tick = 1'b0, ins_valid = 1'b0, ins_bin = 1'b0, ref_ready = 1'b0;
    logic [RW-1:0] ins_row = '0;
    logic ins_ready, ref_valid;
    logic [RW-1:0] ref_row;

    int checks = 0, fails = 0, round_no = 0, cyc = 0;
    bit mf [FB];
    bit ms [SB];

    always #2 clk = ~clk;

    retention_refresh_ctrl #(.ROW_W(RW), .FAST_BITS(FB), .FAST_HASHES(FH),
        .SLOW_BITS(SB), .SLOW_HASHES(SH)) uut (
        .clk(clk), .rst(rst), .clr_filters(clr_filters), .tick(tick),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_row(ins_row), .ins_bin(ins_bin),
        .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_row(ref_row));

    function automatic int unsigned hpos(int unsigned row, int unsigned k, int unsigned w);
        int unsigned v, acc;
        v = row ^ (32'h9E3779B1 * (k + 1));
        acc = 0;
        for (int s = 0; s < 32; s += w) acc ^= (v >> s) & ((1 << w) - 1);
        return acc;
    endfunction

    function automatic bit in_fast(int row);
        for (int k = 0; k < FH; k++) if (!mf[hpos(row, k, 6)]) return 0;
        return 1;
    endfunction

    function automatic bit in_slow(int row);
        for (int k = 0; k < SH; k++) if (!ms[hpos(row, k, 7)]) return 0;
        return 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic insert(int row, bit bin);
        @(negedge clk);
        ins_row = RW'(row); ins_bin = bin; ins_valid = 1'b1;
        while (!ins_ready) @(negedge clk);
        @(posedge clk); #1 ins_valid = 1'b0;
        @(negedge clk);
        check(ins_ready == 1'b0, "R2 busy while inserting", ins_ready, 0);
        while (!ins_ready) @(negedge clk);
        for (int k = 0; k < (bin ? SH : FH); k++) begin
            if (bin) ms[hpos(row, k, 7)] = 1; else mf[hpos(row, k, 6)] = 1;
        end
    endtask

    // Collect refreshed rows of nr consecutive rounds, compare with model.
    task automatic sweep(int nr, bit inject, string req);
        int exp [64];
        int got [64];
        int ne = 0, ng = 0, n = 0;
        bit stalled = 0;
        int srow = 0;
        for (int r = round_no; r < round_no + nr; r++)
            for (int row = 0; row < NROWS; row++)
                if (in_fast(row) || (r % 2 == 0 && in_slow(row)) || r % 4 == 0) begin
                    exp[ne] = row; ne++;
                end
        while (ins_ready) @(negedge clk);
        while (!ins_ready) begin
            if (stalled) begin
                check(ref_valid && ref_row == RW'(srow), "R8 hold under stall", ref_row, srow);
                stalled = 0;
            end
            if (ref_valid) check(ins_ready == 1'b0, "R9 insert blocked", ins_ready, 0);
            ref_ready = (cyc % 3 != 1);
            cyc++;
            if (ref_valid && ref_ready && ng < 64) begin got[ng] = int'(ref_row); ng++; end
            if (ref_valid && !ref_ready) begin stalled = 1; srow = int'(ref_row); end
            n++;
            tick = (inject && n == 4);
            @(negedge clk);
        end
        tick = 1'b0; ref_ready = 1'b0;
        check(ng == ne, {req, " count"}, ng, ne);
        for (int i = 0; i < ne && i < ng; i++)
            check(got[i] == exp[i], {req, " row order"}, got[i], exp[i]);
        round_no += nr;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        foreach (mf[i]) mf[i] = 0;
        foreach (ms[i]) ms[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(ins_ready == 1'b1, "R1 ins_ready after reset", ins_ready, 1);
        check(ref_valid == 1'b0, "R1 ref_valid after reset", ref_valid, 0);
        // R3 round 0, all rows; R6 round 1 with empty filters, none
        pulse_tick(); sweep(1, 0, "R3 full round");
        pulse_tick(); sweep(1, 0, "R6 empty odd round");
        // R2 insertions; R7 row 3 in both
        insert(3, 0); insert(9, 0);
        insert(5, 1); insert(12, 1); insert(3, 1);
        for (int r = 0; r < 8; r++) begin
            pulse_tick(); sweep(1, 0, "R4 R5 R6 R7 binned round");
        end
        // R10 tick during sweep chains one more round
        pulse_tick(); sweep(2, 1, "R10 held tick");
        // R12 tick and insertion together in idle
        @(negedge clk);
        ins_row = 4'd7; ins_bin = 1'b0; ins_valid = 1'b1; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        sweep(1, 0, "R12 tick first");
        @(posedge clk); #1 ins_valid = 1'b0;
        while (!ins_ready) @(negedge clk);
        for (int k = 0; k < FH; k++) mf[hpos(7, k, 6)] = 1;
        pulse_tick(); sweep(1, 0, "R12 insert after sweep");
        // R11 clear
        @(negedge clk); clr_filters = 1'b1;
        @(negedge clk); clr_filters = 1'b0;
        foreach (mf[i]) mf[i] = 0;
        foreach (ms[i]) ms[i] = 0;
        for (int r = 0; r < 3; r++) begin
            pulse_tick(); sweep(1, 0, "R11 cleared filters");
        end
        finish_run();
    end
endmodule